// File: doc/BRIEF.md
# Power-On Reset and Boot-Mode Sequencer

This block brings a serial-bus terminal controller out of power-on reset in an orderly way. It takes an active-low power-on reset pin and a lock indication from the clock PLL. It passes the reset on to the PLL and exposes a synchronised lock flag. After reset releases, it runs an optional self-test window and then a settle window. When both windows have elapsed and the PLL is locked, it raises a flag that allows host access to registers and memory.

Hardware strap pins are sampled once, when the internal reset releases, and held until the next power-on reset. They select:
- whether self-test runs;
- the initial operating mode: remote terminal (RT), bus controller (BC) or Idle;
- whether BC operation is permitted;
- whether more than one RT address may be used;
- which host interface is active (PCI or local CPU bus).

A device-capability input says whether the part is RT-only. An RT boot also requests the Busy bit in the terminal's status word.

All pins are plain control and status levels. There is no streaming data path, so no valid/ready handshake is involved. Interval lengths are parameters in clock cycles. At 160 MHz, 160000 cycles equal 1 ms.

Top module: `por_boot_seq`

## Requirements
- R1: While `por_n` is low, the outputs hold the following values, whatever the other inputs are:
  - `pll_rst_o` is 1.
  - `pll_locked_o`, `host_ready_o`, `bist_active_o`, `busy_o`, `bc_allow_o`, `multi_rt_o` and `pci_sel_o` are 0.
  - `mode_o` is Idle (2'b00).
- R2: After `por_n` is high, `pll_locked_o` follows `pll_lock_in` through a two-flop synchroniser. A rise on the input appears at the output within 3 clock cycles.
- R3: If the latched `strap_bist_off` is 0, `bist_active_o` is high for exactly `BIST_RUN_CYC` consecutive cycles after reset release. If it is 1, `bist_active_o` never goes high. `bist_active_o` is never high together with `host_ready_o`.
- R4: With the PLL already locked, `host_ready_o` rises between WAIT and WAIT+6 cycles after `por_n` rises.
  - WAIT is `WAIT_BIST_CYC` when self-test is enabled and `WAIT_PLAIN_CYC` when it is disabled.
  - Once high, `host_ready_o` stays high until the next power-on reset.
- R5: `host_ready_o` never rises while `pll_locked_o` is low. If lock arrives after the wait has elapsed, `host_ready_o` rises within 2 cycles of `pll_locked_o` rising.
- R6: If the latched `strap_rtboot_n` is 0, then once ready, `mode_o` is RT (2'b01) and `busy_o` is 1.
- R7: If the latched `strap_rtboot_n` is 1, then once ready, `busy_o` is 0 and `mode_o` is:
  - Idle (2'b00) when `cap_rt_only` is 1, or when `strap_bc_off` is 1 (fallback);
  - BC (2'b10) otherwise.
- R8: After reset release, `bc_allow_o` equals NOT `strap_bc_off` AND NOT `cap_rt_only`.
- R9: After reset release, `multi_rt_o` equals NOT `strap_mrt_off`.
- R10: After reset release, `pci_sel_o` equals `strap_host_sel`. A value of 1 selects PCI and 0 selects the CPU bus.
- R11: Straps and capability are sampled on the first cycle after the internal reset releases. Later changes to them have no effect on any output until the next power-on reset.
- R12: Until `host_ready_o` is high, `mode_o` is Idle and `busy_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock (160 MHz nominal) |
| por_n | input | 1 | Power-on reset, active low, asynchronous assert |
| pll_lock_in | input | 1 | Raw lock indication from the PLL |
| strap_bist_off | input | 1 | 1 = skip self-test |
| strap_rtboot_n | input | 1 | 0 = boot into RT mode with Busy set |
| strap_bc_off | input | 1 | 1 = BC mode forbidden |
| strap_mrt_off | input | 1 | 1 = single RT address only |
| strap_host_sel | input | 1 | 1 = PCI host interface, 0 = CPU bus |
| cap_rt_only | input | 1 | Device capability: 1 = RT-only part |
| pll_rst_o | output | 1 | Reset to the PLL, active high |
| pll_locked_o | output | 1 | Synchronised PLL lock flag |
| bist_active_o | output | 1 | High during the self-test window |
| host_ready_o | output | 1 | Host may access registers and memory |
| mode_o | output | 2 | Operating mode: 00 Idle, 01 RT, 10 BC |
| busy_o | output | 1 | Request to set the Busy status-word bit |
| bc_allow_o | output | 1 | BC operation permitted |
| multi_rt_o | output | 1 | Multiple RT addresses permitted |
| pci_sel_o | output | 1 | PCI host interface selected |

## Verification
The bench sweeps all 64 combinations of the five straps and the capability input. Each run checks the reset state, measures the cycle count to host-ready against the right wait, counts the self-test cycles and checks the decoded mode and permissions.

A design that picks the wrong wait for the self-test setting, or lets the self-test window run one cycle short or long, fails the measured counts. A decoder that boots into BC with BC disabled, or ignores the RT-only class, shows the wrong `mode_o` in the affected combinations.

After each run all straps are inverted. A design that samples them continuously then changes its outputs. A separate run holds PLL lock off past the wait: a sequencer that raises ready on the timer alone, or that misses a late lock, is caught there.

// File: rtl/por_boot_pkg.sv
package por_boot_pkg;

  typedef enum logic [1:0] {
    MODE_IDLE = 2'b00,
    MODE_RT   = 2'b01,
    MODE_BC   = 2'b10
  } boot_mode_e;

  typedef enum logic [1:0] {
    PH_START,
    PH_BIST,
    PH_SETTLE,
    PH_READY
  } phase_e;

  typedef struct packed {
    logic rt_only;
    logic host_sel;
    logic mrt_off;
    logic bc_off;
    logic rtboot_n;
    logic bist_off;
  } strap_t;

endpackage

// File: rtl/por_sync2.sv
// Multi-stage synchroniser with asynchronous clear.
module por_sync2 #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sh;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sh <= '0;
    else         sh <= {sh[STAGES-2:0], d};
  end

  assign q = sh[STAGES-1];
endmodule

// File: rtl/por_strap_latch.sv
// Captures the strap set once, on the first cycle out of reset.
module por_strap_latch
  import por_boot_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  strap_t raw,
  output strap_t held,
  output logic   taken
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held  <= '0;
      taken <= 1'b0;
    end else if (!taken) begin
      held  <= raw;
      taken <= 1'b1;
    end
  end
endmodule

// File: rtl/por_phase_timer.sv
// Self-test window, settle window and lock gating for host readiness.
module por_phase_timer
  import por_boot_pkg::*;
#(
  parameter int WAIT_BIST_CYC  = 160000,
  parameter int WAIT_PLAIN_CYC = 80000,
  parameter int BIST_RUN_CYC   = 120000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic taken,
  input  logic bist_off,
  input  logic locked,
  output logic bist_active,
  output logic ready
);
  localparam int MAX_WAIT = (WAIT_BIST_CYC > WAIT_PLAIN_CYC) ? WAIT_BIST_CYC : WAIT_PLAIN_CYC;
  localparam int CW       = $clog2(MAX_WAIT + 1);
  localparam logic [CW-1:0] BIST_LAST  = CW'(BIST_RUN_CYC - 1);
  localparam logic [CW-1:0] TGT_BIST   = CW'(WAIT_BIST_CYC - 1);
  localparam logic [CW-1:0] TGT_PLAIN  = CW'(WAIT_PLAIN_CYC - 1);

  phase_e        phase;
  logic [CW-1:0] cnt;
  logic [CW-1:0] tgt;
  logic          at_tgt;

  assign tgt    = bist_off ? TGT_PLAIN : TGT_BIST;
  assign at_tgt = (cnt >= tgt);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= PH_START;
      cnt   <= '0;
    end else begin
      unique case (phase)
        PH_START: begin
          cnt <= '0;
          if (taken) phase <= bist_off ? PH_SETTLE : PH_BIST;
        end
        PH_BIST: begin
          cnt <= cnt + 1'b1;
          if (cnt == BIST_LAST) phase <= PH_SETTLE;
        end
        PH_SETTLE: begin
          if (!at_tgt) cnt <= cnt + 1'b1;
          if (at_tgt && locked) phase <= PH_READY;
        end
        PH_READY: phase <= PH_READY;
        default:  phase <= PH_START;
      endcase
    end
  end

  assign bist_active = (phase == PH_BIST);
  assign ready       = (phase == PH_READY);
endmodule

// File: rtl/por_mode_decode.sv
// Turns the held straps into boot mode and permission levels.
module por_mode_decode
  import por_boot_pkg::*;
(
  input  strap_t     held,
  input  logic       taken,
  input  logic       ready,
  output boot_mode_e mode,
  output logic       busy,
  output logic       bc_allow,
  output logic       multi_rt,
  output logic       pci_sel
);
  boot_mode_e boot;

  always_comb begin
    if (!held.rtboot_n)                    boot = MODE_RT;
    else if (!held.rt_only && !held.bc_off) boot = MODE_BC;
    else                                   boot = MODE_IDLE;

    mode     = ready ? boot : MODE_IDLE;
    busy     = ready & ~held.rtboot_n;
    bc_allow = taken & ~held.bc_off & ~held.rt_only;
    multi_rt = taken & ~held.mrt_off;
    pci_sel  = taken & held.host_sel;
  end
endmodule

// File: rtl/por_boot_seq.sv
module por_boot_seq
  import por_boot_pkg::*;
#(
  parameter int WAIT_BIST_CYC  = 160000,
  parameter int WAIT_PLAIN_CYC = 80000,
  parameter int BIST_RUN_CYC   = 120000,
  parameter int SYNC_STAGES    = 2
) (
  input  logic       clk,
  input  logic       por_n,
  input  logic       pll_lock_in,
  input  logic       strap_bist_off,
  input  logic       strap_rtboot_n,
  input  logic       strap_bc_off,
  input  logic       strap_mrt_off,
  input  logic       strap_host_sel,
  input  logic       cap_rt_only,
  output logic       pll_rst_o,
  output logic       pll_locked_o,
  output logic       bist_active_o,
  output logic       host_ready_o,
  output logic [1:0] mode_o,
  output logic       busy_o,
  output logic       bc_allow_o,
  output logic       multi_rt_o,
  output logic       pci_sel_o
);
  logic       rst_n_int;
  strap_t     raw, held;
  logic       taken;
  boot_mode_e mode;

  assign pll_rst_o = ~por_n;

  por_sync2 #(.STAGES(SYNC_STAGES)) u_rst_sync (
    .clk(clk), .arst_n(por_n), .d(1'b1), .q(rst_n_int)
  );

  por_sync2 #(.STAGES(SYNC_STAGES)) u_lock_sync (
    .clk(clk), .arst_n(por_n), .d(pll_lock_in), .q(pll_locked_o)
  );

  assign raw = '{rt_only:  cap_rt_only,
                 host_sel: strap_host_sel,
                 mrt_off:  strap_mrt_off,
                 bc_off:   strap_bc_off,
                 rtboot_n: strap_rtboot_n,
                 bist_off: strap_bist_off};

  por_strap_latch u_latch (
    .clk(clk), .rst_n(rst_n_int), .raw(raw), .held(held), .taken(taken)
  );

  por_phase_timer #(
    .WAIT_BIST_CYC(WAIT_BIST_CYC),
    .WAIT_PLAIN_CYC(WAIT_PLAIN_CYC),
    .BIST_RUN_CYC(BIST_RUN_CYC)
  ) u_timer (
    .clk(clk), .rst_n(rst_n_int), .taken(taken), .bist_off(held.bist_off),
    .locked(pll_locked_o), .bist_active(bist_active_o), .ready(host_ready_o)
  );

  por_mode_decode u_dec (
    .held(held), .taken(taken), .ready(host_ready_o), .mode(mode),
    .busy(busy_o), .bc_allow(bc_allow_o), .multi_rt(multi_rt_o), .pci_sel(pci_sel_o)
  );

  assign mode_o = mode;
endmodule

// File: rtl/por_boot_seq_chk.sv
module por_boot_seq_chk (
  input logic       clk,
  input logic       por_n,
  input logic       pll_lock_in,
  input logic       strap_bist_off,
  input logic       strap_rtboot_n,
  input logic       strap_bc_off,
  input logic       strap_mrt_off,
  input logic       strap_host_sel,
  input logic       cap_rt_only,
  input logic       pll_rst_o,
  input logic       pll_locked_o,
  input logic       bist_active_o,
  input logic       host_ready_o,
  input logic [1:0] mode_o,
  input logic       busy_o,
  input logic       bc_allow_o,
  input logic       multi_rt_o,
  input logic       pci_sel_o
);
  a_r1_reset_hold: assert property (@(posedge clk)
    !por_n |-> (pll_rst_o && !pll_locked_o && !host_ready_o && !bist_active_o));

  a_r3_bist_not_ready: assert property (@(posedge clk) disable iff (!por_n)
    bist_active_o |-> !host_ready_o);

  a_r4_ready_sticky: assert property (@(posedge clk) disable iff (!por_n)
    host_ready_o |=> host_ready_o);

  a_r5_ready_needs_lock: assert property (@(posedge clk) disable iff (!por_n)
    $rose(host_ready_o) |-> pll_locked_o);

  a_r6_busy_only_rt: assert property (@(posedge clk) disable iff (!por_n)
    busy_o |-> (mode_o == 2'b01));

  a_r8_bc_permitted: assert property (@(posedge clk) disable iff (!por_n)
    (mode_o == 2'b10) |-> bc_allow_o);

  a_r11_held_after_ready: assert property (@(posedge clk) disable iff (!por_n)
    host_ready_o |=> ($stable(mode_o) && $stable(bc_allow_o) &&
                      $stable(multi_rt_o) && $stable(pci_sel_o) && $stable(busy_o)));

  a_r12_idle_before_ready: assert property (@(posedge clk) disable iff (!por_n)
    !host_ready_o |-> (mode_o == 2'b00 && !busy_o));
endmodule

bind por_boot_seq por_boot_seq_chk u_chk (.*);

// File: tb/por_boot_seq_tb.sv
module por_boot_seq_tb;
  localparam int WB = 40;
  localparam int WP = 20;
  localparam int BR = 12;

  logic clk = 1'b0;
  logic por_n = 1'b0;
  logic pll_lock_in = 1'b0;
  logic [5:0] st = '0;  // {rt_only, host_sel, mrt_off, bc_off, rtboot_n, bist_off}
  logic pll_rst_o, pll_locked_o, bist_active_o, host_ready_o;
  logic [1:0] mode_o;
  logic busy_o, bc_allow_o, multi_rt_o, pci_sel_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  por_boot_seq #(.WAIT_BIST_CYC(WB), .WAIT_PLAIN_CYC(WP), .BIST_RUN_CYC(BR)) u_dut (
    .clk(clk), .por_n(por_n), .pll_lock_in(pll_lock_in),
    .strap_bist_off(st[0]), .strap_rtboot_n(st[1]), .strap_bc_off(st[2]),
    .strap_mrt_off(st[3]), .strap_host_sel(st[4]), .cap_rt_only(st[5]),
    .pll_rst_o(pll_rst_o), .pll_locked_o(pll_locked_o), .bist_active_o(bist_active_o),
    .host_ready_o(host_ready_o), .mode_o(mode_o), .busy_o(busy_o),
    .bc_allow_o(bc_allow_o), .multi_rt_o(multi_rt_o), .pci_sel_o(pci_sel_o)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic report();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  task automatic check_outputs(input logic [5:0] s, input string tag);
    int em;
    if (!s[1])              em = 1;
    else if (!s[5] && !s[2]) em = 2;
    else                    em = 0;
    chk(mode_o == 2'(em), {tag, " R6/R7 mode"}, mode_o, em);
    chk(busy_o == !s[1], {tag, " R6 busy"}, busy_o, !s[1]);
    chk(bc_allow_o == (!s[2] && !s[5]), {tag, " R8 bc_allow"}, bc_allow_o, !s[2] && !s[5]);
    chk(multi_rt_o == !s[3], {tag, " R9 multi_rt"}, multi_rt_o, !s[3]);
    chk(pci_sel_o == s[4], {tag, " R10 pci_sel"}, pci_sel_o, s[4]);
  endtask

  task automatic hold_reset(input logic [5:0] s);
    @(negedge clk);
    por_n = 1'b0; pll_lock_in = 1'b1; st = s;
    repeat (3) @(negedge clk);
    chk(pll_rst_o && !pll_locked_o && !host_ready_o && !bist_active_o && mode_o == 2'b00 &&
        !busy_o && !bc_allow_o && !multi_rt_o && !pci_sel_o,
        "R1 reset state", {pll_rst_o, pll_locked_o, host_ready_o, bist_active_o, mode_o,
        busy_o, bc_allow_o, multi_rt_o, pci_sel_o}, 10'b1000000000);
    pll_lock_in = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=1 expected=0");
      report();
    end
  end

  initial begin
    for (int s = 0; s < 64; s++) begin
      int n, ready_at, lock_at, bist_cnt, wait_c;
      bit pre_ready_idle;
      hold_reset(6'(s));
      por_n = 1'b1;
      n = 0; ready_at = -1; lock_at = -1; bist_cnt = 0; pre_ready_idle = 1'b1;
      wait_c = st[0] ? WP : WB;
      while (ready_at < 0 && n < 200) begin
        @(posedge clk);
        n++;
        @(negedge clk);
        if (n == 3) pll_lock_in = 1'b1;
        if (pll_locked_o && lock_at < 0) lock_at = n;
        if (bist_active_o) bist_cnt++;
        if (!host_ready_o && (mode_o != 2'b00 || busy_o)) pre_ready_idle = 1'b0;
        if (host_ready_o) ready_at = n;
      end
      chk(lock_at - 3 >= 1 && lock_at - 3 <= 3, "R2 lock latency", lock_at - 3, 2);
      chk(bist_cnt == (st[0] ? 0 : BR), "R3 bist window", bist_cnt, st[0] ? 0 : BR);
      chk(ready_at >= wait_c && ready_at <= wait_c + 6, "R4 ready time", ready_at, wait_c);
      chk(pre_ready_idle, "R12 idle before ready", 0, 1);
      check_outputs(6'(s), "run");
      // R11: invert every strap after the fact
      st = ~6'(s);
      repeat (5) @(negedge clk);
      chk(host_ready_o, "R4 ready sticky", host_ready_o, 1);
      check_outputs(6'(s), "R11 after strap change");
    end

    // R5: lock arrives late
    hold_reset(6'b000001);
    por_n = 1'b1;
    repeat (WP + 20) @(negedge clk);
    chk(!host_ready_o, "R5 no ready without lock", host_ready_o, 0);
    pll_lock_in = 1'b1;
    begin
      int lk, rd;
      lk = -1; rd = -1;
      for (int i = 1; i <= 8; i++) begin
        @(negedge clk);
        if (pll_locked_o && lk < 0) lk = i;
        if (host_ready_o && rd < 0) rd = i;
      end
      chk(lk >= 1 && lk <= 3, "R2 late lock sync", lk, 2);
      chk(rd > 0 && rd > lk - 1 && rd - lk <= 2, "R5 ready after lock", rd - lk, 1);
    end

    done = 1'b1;
    report();
  end
endmodule